// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a 32-bit register port, with one address, one write strobe, write data and combinational read data. It holds a configuration word and a status word. The configuration word can be replaced only by a pair of back-to-back control writes. The first write must be a fixed arming word. The second write must carry a key byte in bits 23:16. Any other write is dropped and disarms the lock. Software enables, refreshes and stops the timer by repeating this pair.

When enabled, a prescaler divides the clock by one of four ratios that grow by a parameterised power of two. Each prescaler wrap moves a 16-bit down-counter one step toward zero. The counter starts from the reload field. When the count runs out, the block raises a one-cycle reset request, halts the counter and sets a sticky cause flag. A warm reset (`sysRstN`) clears the configuration and the counter but keeps the cause flag, so software can see why the system restarted. Only the power-on reset (`porRstN`) or the next accepted unlock pair clears the flag.

Top module: `keyed_wdt`

## Requirements
- R1: With power-on reset held, the control word, the status word and `resetReq` all read 0.
- R2: A control write (offset 0x0) of exactly 0x00BE0000 arms the lock and leaves the control word as it was.
- R3: An armed control write whose bits 23:16 equal 0xDC is accepted. It stores enable = bit 31, power = bits 27:26, divider select = bits 25:24 and reload = bits 15:0. The control word reads back those same bit positions and zero everywhere else.
- R4: An armed control write whose key byte is not 0xDC disarms the lock and changes nothing. A keyed write that does not directly follow the arming word is ignored.
- R5: A write to any offset other than 0x0 while the lock is armed disarms it.
- R6: With enable set, the counter falls by one every 2^(select*DIV_STEP) clocks (with the default DIV_STEP = 6, select 3 divides by 262144).
- R7: `resetReq` goes high for exactly one clock, max(reload,1)*ratio clocks after the accepting edge. The counter then holds 0 until the next accepted pair.
- R8: Status bit 30 is the cause flag. It is set with `resetReq`, survives `sysRstN`, and is cleared by `porRstN` or by an accepted pair.
- R9: An accepted pair with enable set reloads the counter and restarts the prescaler. If it lands on the edge where the count would expire, the reload wins and no request is raised.
- R10: An accepted pair with enable clear stops the prescaler and the counter, so no request is ever raised.
- R11: The status word (offset 0x8) is enable in bit 31, cause in bit 30 and the live counter in bits 15:0, with other bits zero. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous; clears everything |
| sysRstN | input | 1 | Warm reset, active low, synchronous; keeps the cause flag |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| resetReq | output | 1 | One-cycle reset request on expiry |

## Verification
A write takes effect on the rising edge on which it is presented. The bench therefore drives each write at a falling edge and reads the new control and status words at the next falling edge. The counter's first step comes `ratio` clocks after the accepting edge, and `resetReq` is high in the cycle after edge max(reload,1)*ratio. The bench counts falling edges from the accepting edge and compares each against these values. It also checks that the request is low again one falling edge later. The refresh case places the keyed write exactly on the expiring edge, so that edge's result is checked directly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [31:0] ARM_WORD   = 32'h00BE_0000;
  localparam logic [7:0]  KEY_BYTE   = 8'hDC;

  typedef struct packed {
    logic load;    // accepted keyed write this cycle
    logic rdCtrl;  // address selects control word
    logic rdStat;  // address selects status word
  } wdtStrb_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFF = 0,
  parameter int STAT_OFF = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output wdtStrb_t          strb
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

  logic armedQ;
  logic isCtrl;
  logic armHit;

  assign isCtrl = (addr == CTRL_A);
  assign armHit = wrEn && isCtrl && !armedQ && (wrData == ARM_WORD);

  always_ff @(posedge clk) begin
    if (!rstN)     armedQ <= 1'b0;
    else if (wrEn) armedQ <= armHit;
  end

  always_comb begin
    strb.load   = wrEn && isCtrl && armedQ && (wrData[23:16] == KEY_BYTE);
    strb.rdCtrl = isCtrl;
    strb.rdStat = (addr == STAT_A);
  end

  AST_ARM_ON_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isCtrl && !armedQ && wrData == ARM_WORD) |=> armedQ); // R2
  AST_DISARM_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && armedQ) |=> !armedQ); // R4
  AST_IDLE_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> $stable(armedQ)); // R5
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int DIV_STEP = 6,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        sysRstN,
  input  wdtStrb_t    strb,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        resetReq
);
  localparam int PRE_W = (3 * DIV_STEP > 0) ? 3 * DIV_STEP : 1;
  localparam int NSEL  = 4;

  logic             rstAll;
  logic             cfgEn;
  logic [1:0]       cfgPwr;
  logic [1:0]       cfgDiv;
  logic [CNT_W-1:0] cfgReload;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] limTab [NSEL];
  logic [PRE_W-1:0] divMax;
  logic             stopped;
  logic             causeQ;
  logic             reqQ;
  logic             running;
  logic             tick;
  logic             expire;
  logic [31:0]      ctrlWord;
  logic [31:0]      statWord;

  assign rstAll = porRstN & sysRstN;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign limTab[g] = PRE_W'((64'd1 << (g * DIV_STEP)) - 64'd1);
  end

  assign divMax  = limTab[cfgDiv];
  assign running = cfgEn && !stopped;
  assign tick    = running && (pre == divMax);
  assign expire  = !strb.load && tick && (cnt <= CNT_W'(1));

  // configuration word
  always_ff @(posedge clk) begin
    if (!rstAll) begin
      cfgEn     <= 1'b0;
      cfgPwr    <= 2'b00;
      cfgDiv    <= 2'b00;
      cfgReload <= '0;
    end else if (strb.load) begin
      cfgEn     <= wrData[31];
      cfgPwr    <= wrData[27:26];
      cfgDiv    <= wrData[25:24];
      cfgReload <= wrData[CNT_W-1:0];
    end
  end

  // prescaler
  always_ff @(posedge clk) begin
    if (!rstAll)        pre <= '0;
    else if (strb.load) pre <= '0;
    else if (running)   pre <= (pre == divMax) ? '0 : pre + PRE_W'(1);
  end

  // down-counter and request
  always_ff @(posedge clk) begin
    if (!rstAll) begin
      cnt     <= '0;
      stopped <= 1'b0;
      reqQ    <= 1'b0;
    end else begin
      reqQ <= 1'b0;
      if (strb.load) begin
        cnt     <= wrData[CNT_W-1:0];
        stopped <= 1'b0;
      end else if (expire) begin
        cnt     <= '0;
        stopped <= 1'b1;
        reqQ    <= 1'b1;
      end else if (tick) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // sticky cause flag, kept across warm reset
  always_ff @(posedge clk) begin
    if (!porRstN)                causeQ <= 1'b0;
    else if (strb.load)          causeQ <= 1'b0;
    else if (sysRstN && expire)  causeQ <= 1'b1;
  end

  assign ctrlWord = {cfgEn, 3'b000, cfgPwr, cfgDiv, 8'h00, 16'(cfgReload)};
  assign statWord = {cfgEn, causeQ, 14'h0000, 16'(cnt)};

  always_comb begin
    if (strb.rdCtrl)      rdData = ctrlWord;
    else if (strb.rdStat) rdData = statWord;
    else                  rdData = '0;
  end

  assign resetReq = reqQ;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstAll)
    reqQ |=> !reqQ); // R7
  AST_REQ_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rstAll)
    reqQ |-> causeQ); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstAll)
    !strb.load |=> $stable(ctrlWord)); // R4
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstAll)
    (running && !strb.load) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstAll)
    (!cfgEn && !strb.load) |=> ($stable(cnt) && !reqQ)); // R10
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rstAll)
    (stopped && !strb.load) |=> (cnt == '0)); // R7
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIV_STEP = 6,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              resetReq
);
  wdtStrb_t strb;
  logic     ctrlRstN;

  assign ctrlRstN = porRstN & sysRstN;

  wdt_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFF(0), .STAT_OFF(8)) i_ctrl (
    .clk    (clk),
    .rstN   (ctrlRstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .strb   (strb)
  );

  wdt_datapath #(.DIV_STEP(DIV_STEP), .CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .sysRstN  (sysRstN),
    .strb     (strb),
    .wrData   (wrData),
    .rdData   (rdData),
    .resetReq (resetReq)
  );
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int ADDR_W = 4;
  localparam int STEP   = 2;

  logic              clk = 1'b0;
  logic              porRstN = 1'b0;
  logic              sysRstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              resetReq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  keyed_wdt #(.ADDR_W(ADDR_W), .DIV_STEP(STEP), .CNT_W(16)) i_keyed_wdt (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .resetReq(resetReq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung act=%0d exp<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData; addr = '0;
  endtask

  task automatic cfg(input logic [31:0] d);
    wr(4'h0, 32'h00BE_0000);
    wr(4'h0, d);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(4'h0, v); chk("R1 ctrl at reset", v, 32'h0);
    rd(4'h8, v); chk("R1 status at reset", v, 32'h0);
    chk("R1 resetReq at reset", {31'h0, resetReq}, 32'h0);
    porRstN = 1'b1; sysRstN = 1'b1;
    @(negedge clk);

    // R2: arming word alone changes nothing
    wr(4'h0, 32'h00BE_0000);
    rd(4'h0, v); chk("R2 arm leaves ctrl", v, 32'h0);
    wr(4'h0, 32'h0000_0000); // disarm
    // R3: field placement
    cfg(32'h8EDC_1234);
    rd(4'h0, v); chk("R3 ctrl readback", v, 32'h8E00_1234);
    // R11: status layout, unknown offset
    cfg(32'h83DC_0010);
    rd(4'h8, v); chk("R11 status layout", v, 32'h8000_0010);
    rd(4'h4, v); chk("R11 unknown offset", v, 32'h0);
    // R4: wrong key after arm, then orphan keyed write
    wr(4'h0, 32'h00BE_0000);
    wr(4'h0, 32'h00AA_0005);
    rd(4'h0, v); chk("R4 wrong key ignored", v, 32'h8300_0010);
    wr(4'h0, 32'h80DC_0007);
    rd(4'h0, v); chk("R4 keyed without arm ignored", v, 32'h8300_0010);
    // R5: other-offset write disarms
    wr(4'h0, 32'h00BE_0000);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h0, 32'h80DC_0007);
    rd(4'h0, v); chk("R5 other offset disarms", v, 32'h8300_0010);

    // R6/R7/R8 sweep over divider select and reload
    for (int s = 0; s < 4; s++) begin
      for (int ri = 0; ri < 4; ri++) begin
        int rl; int ratio; int n; int k; bit traceOk; bit early;
        rl = (ri == 0) ? 0 : (ri == 1) ? 1 : (ri == 2) ? 3 : 6;
        ratio = 1 << (s * STEP);
        n = ((rl == 0) ? 1 : rl) * ratio;
        cfg({1'b1, 5'b0, 2'(s), 8'hDC, 16'(rl)});
        rd(4'h8, v); chk("R8 cause cleared by load", {31'h0, v[30]}, 32'h0);
        traceOk = 1'b1; early = 1'b0; k = 0;
        while (k < n - 1) begin
          @(negedge clk); k++;
          rd(4'h8, v);
          if (v[15:0] != 16'((rl == 0) ? 0 : rl - k / ratio)) traceOk = 1'b0;
          if (resetReq) early = 1'b1;
        end
        chk("R6 counter trace", {31'h0, traceOk}, 32'h1);
        chk("R7 no early request", {31'h0, early}, 32'h0);
        @(negedge clk);
        chk("R7 request at expiry", {31'h0, resetReq}, 32'h1);
        rd(4'h8, v); chk("R8 cause and zero count", v, 32'hC000_0000);
        @(negedge clk);
        chk("R7 request one cycle", {31'h0, resetReq}, 32'h0);
        repeat (3) @(negedge clk);
        rd(4'h8, v); chk("R7 counter held", v, 32'hC000_0000);
      end
    end

    // R8: warm reset keeps cause, power-on reset clears it
    sysRstN = 1'b0; repeat (2) @(negedge clk); sysRstN = 1'b1;
    rd(4'h8, v); chk("R8 cause survives warm reset", v, 32'h4000_0000);
    rd(4'h0, v); chk("R8 ctrl cleared by warm reset", v, 32'h0);
    porRstN = 1'b0; repeat (2) @(negedge clk); porRstN = 1'b1;
    rd(4'h8, v); chk("R8 cause cleared by por", v, 32'h0);

    // R9: refresh landing on the expiring edge
    begin
      int k; bit early;
      early = 1'b0;
      cfg(32'h80DC_0004);
      repeat (2) begin @(negedge clk); if (resetReq) early = 1'b1; end
      wr(4'h0, 32'h00BE_0000); if (resetReq) early = 1'b1;
      wr(4'h0, 32'h80DC_0004); if (resetReq) early = 1'b1;
      chk("R9 refresh beats expiry", {31'h0, early}, 32'h0);
      rd(4'h8, v); chk("R9 counter reloaded", v, 32'h8000_0004);
      k = 0;
      while (!resetReq && k < 50) begin @(negedge clk); k++; end
      chk("R9 expiry after refresh", 32'(k), 32'd4);
    end

    // R10: disabled timer never fires
    begin
      bit fired;
      fired = 1'b0;
      cfg(32'h00DC_0003);
      repeat (40) begin @(negedge clk); if (resetReq) fired = 1'b1; end
      chk("R10 no request when disabled", {31'h0, fired}, 32'h0);
      rd(4'h8, v); chk("R10 counter frozen", v, 32'h0000_0003);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule